// File: doc/BRIEF.md
# Grouped Two-Bit Ripple Adder

This block adds two unsigned operands of a parameterised even width, plus an incoming carry. It gives a sum of the same width and a final carry-out. The datapath is cut into two-bit groups. Carry passes from one group to the next and nowhere else.

Inside a group, none of the three outputs is built from an intermediate carry. The five group inputs are decoded into one of 32 product terms. Each output is the OR of a fixed subset of those terms. This makes every output a flat two-level function of the five inputs. The group delay is therefore one decode and one OR, whatever the width.

The block is purely combinational, with no clock and no state. It is meant to sit inside a larger datapath whose pipeline registers surround it.

Top module: `grp_ripple_adder`

## Requirements
- R1: In every group, the low sum bit equals the XOR of the low A bit, the low B bit and the group carry-in.
- R2: In every group, the high sum bit equals bit 1 of the value {A_hi,A_lo} + {B_hi,B_lo} + carry-in. The group term index is {carry-in, B_hi, B_lo, A_hi, A_lo}, with carry-in as the most significant bit. Exactly one of the 32 terms is active for any index.
- R3: In every group, the carry-out equals bit 2 of that same three-bit value.
- R4: `sum` equals the low WIDTH bits of op_a + op_b + carry_in.
- R5: `carry_out` equals bit WIDTH of op_a + op_b + carry_in.
- R6: `carry_in` enters the least significant group: with both operands zero and carry_in = 1, `sum` is 1 and `carry_out` is 0.
- R7: A carry crosses every group. All-ones plus zero with carry_in = 1 gives `sum` = 0 and `carry_out` = 1.
- R8: Group k covers bits 2k and 2k+1, and its carry feeds group k+1. When bit 2k+1 is set in both operands, only bit 2k+2 of the result is set. For the top group, that bit is `carry_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand, unsigned |
| op_b | input | WIDTH | Second operand, unsigned |
| carry_in | input | 1 | Carry into the least significant group |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of the most significant group |

## Verification
The assertions are immediate checks that compare each group and the whole adder with the arithmetic total. They assume every input bit is a known 0 or 1. They are skipped while any operand bit, or the carry, is unknown. The bench never leaves inputs floating. Before any check, it drives every operand and carry bit to a defined value at a clock edge. It then samples half a period later, once the combinational outputs have settled. The term decoder's one-hot property likewise assumes a fully known index. The exhaustive group sweep and the exhaustive four-bit sweep stay inside that domain.

// File: rtl/grp_add_pkg.sv
package grp_add_pkg;
  localparam int GRP_IN    = 5;
  localparam int GRP_TERMS = 1 << GRP_IN;
  localparam int GRP_OUT   = 3;

  // Term index layout: bit4 carry-in, bit3 B_hi, bit2 B_lo, bit1 A_hi, bit0 A_lo.
  // Returns which of the 32 terms make output column col equal 1.
  function automatic logic [GRP_TERMS-1:0] term_mask(input int col);
    logic [GRP_TERMS-1:0] m;
    logic [2:0]           v;
    m = '0;
    for (int i = 0; i < GRP_TERMS; i++) begin
      v    = 3'(i & 3) + 3'((i >> 2) & 3) + 3'((i >> 4) & 1);
      m[i] = v[col];
    end
    return m;
  endfunction
endpackage

// File: rtl/grp2_term_dec.sv
module grp2_term_dec #(
  parameter int N_IN = 5
) (
  input  logic [N_IN-1:0]      idx,
  output logic [(1<<N_IN)-1:0] hot
);
  localparam int N_TERMS = 1 << N_IN;

  for (genvar i = 0; i < N_TERMS; i++) begin : g_term
    assign hot[i] = (idx == N_IN'(i));
  end

  always_comb begin
    if (!$isunknown(idx)) begin
      p_onehot_term_r2: assert ($countones(hot) == 1)
        else $error("term decoder not one-hot");
    end
  end
endmodule

// File: rtl/grp2_or_plane.sv
module grp2_or_plane #(
  parameter int                   N_TERMS   = 32,
  parameter logic [N_TERMS-1:0]   TERM_MASK = '0
) (
  input  logic [N_TERMS-1:0] hot,
  output logic               y
);
  assign y = |(hot & TERM_MASK);
endmodule

// File: rtl/grp2_stage.sv
module grp2_stage
  import grp_add_pkg::*;
(
  input  logic a_lo,
  input  logic a_hi,
  input  logic b_lo,
  input  logic b_hi,
  input  logic c_in,
  output logic s_lo,
  output logic s_hi,
  output logic c_out
);
  logic [GRP_IN-1:0]    idx;
  logic [GRP_TERMS-1:0] hot;
  logic [GRP_OUT-1:0]   res;

  assign idx = {c_in, b_hi, b_lo, a_hi, a_lo};

  grp2_term_dec #(.N_IN(GRP_IN)) u_dec (
    .idx (idx),
    .hot (hot)
  );

  for (genvar o = 0; o < GRP_OUT; o++) begin : g_col
    grp2_or_plane #(
      .N_TERMS   (GRP_TERMS),
      .TERM_MASK (term_mask(o))
    ) u_plane (
      .hot (hot),
      .y   (res[o])
    );
  end

  assign s_lo  = res[0];
  assign s_hi  = res[1];
  assign c_out = res[2];

  always_comb begin
    if (!$isunknown(idx)) begin
      p_low_parity_r1: assert (s_lo == (a_lo ^ b_lo ^ c_in))
        else $error("group low sum bit wrong");
      p_high_sum_r2: assert (s_hi == 1'(({1'b0, a_hi, a_lo} + {1'b0, b_hi, b_lo} + {2'b0, c_in}) >> 1))
        else $error("group high sum bit wrong");
      p_group_carry_r3: assert (c_out == (({1'b0, a_hi, a_lo} + {1'b0, b_hi, b_lo} + {2'b0, c_in}) > 3'd3))
        else $error("group carry-out wrong");
    end
  end
endmodule

// File: rtl/grp_ripple_adder.sv
module grp_ripple_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  localparam int N_GRP = WIDTH / 2;

  if ((WIDTH % 2) != 0 || WIDTH < 2) begin : g_bad_width
    $error("WIDTH must be even and at least 2");
  end

  logic [N_GRP:0] chain;
  assign chain[0] = carry_in;

  for (genvar k = 0; k < N_GRP; k++) begin : g_grp
    grp2_stage u_stage (
      .a_lo  (op_a[2*k]),
      .a_hi  (op_a[2*k+1]),
      .b_lo  (op_b[2*k]),
      .b_hi  (op_b[2*k+1]),
      .c_in  (chain[k]),
      .s_lo  (sum[2*k]),
      .s_hi  (sum[2*k+1]),
      .c_out (chain[k+1])
    );
  end

  assign carry_out = chain[N_GRP];

  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, op_a} + {1'b0, op_b} + (WIDTH+1)'(carry_in);

  always_comb begin
    if (!$isunknown({op_a, op_b, carry_in})) begin
      p_sum_match_r4: assert (sum == ref_total[WIDTH-1:0])
        else $error("sum mismatch");
      p_carry_match_r5: assert (carry_out == ref_total[WIDTH])
        else $error("carry_out mismatch");
    end
  end
endmodule

// File: tb/sim_grp_ripple_adder.sv
module sim_grp_ripple_adder;
  localparam int W  = 32;
  localparam int WS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0]  a, b, s;
  logic          ci, co;
  logic [WS-1:0] sa, sb, ss;
  logic          sci, sco;
  logic [4:0]    gi;
  logic          g_s0, g_s1, g_c1;

  grp_ripple_adder #(.WIDTH(W)) u0 (
    .op_a(a), .op_b(b), .carry_in(ci), .sum(s), .carry_out(co));
  grp_ripple_adder #(.WIDTH(WS)) u_small (
    .op_a(sa), .op_b(sb), .carry_in(sci), .sum(ss), .carry_out(sco));
  grp2_stage u_grp (
    .a_lo(gi[0]), .a_hi(gi[1]), .b_lo(gi[2]), .b_hi(gi[3]), .c_in(gi[4]),
    .s_lo(g_s0), .s_hi(g_s1), .c_out(g_c1));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_big(input string req, input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    logic [W:0] e;
    @(posedge clk);
    a = x; b = y; ci = c;
    @(negedge clk);
    e = {1'b0, x} + {1'b0, y} + (W+1)'(c);
    chk({req, "/R4 sum"}, 64'(s), 64'(e[W-1:0]));
    chk({req, "/R5 carry"}, 64'(co), 64'(e[W]));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    a = '0; b = '0; ci = 1'b0; sa = '0; sb = '0; sci = 1'b0; gi = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 idle sum", 64'(s), 64'd0);
    chk("R5 idle carry", 64'(co), 64'd0);

    // R1 R2 R3: every term index of one group
    for (int i = 0; i < 32; i++) begin
      logic [2:0] v;
      @(posedge clk);
      gi = 5'(i);
      @(negedge clk);
      v = 3'(i & 3) + 3'((i >> 2) & 3) + 3'((i >> 4) & 1);
      chk("R1 low sum", 64'(g_s0), 64'(v[0]));
      chk("R2 high sum", 64'(g_s1), 64'(v[1]));
      chk("R3 group carry", 64'(g_c1), 64'(v[2]));
    end

    // R4 R5: exhaustive on the small chain
    for (int x = 0; x < (1 << WS); x++) begin
      for (int y = 0; y < (1 << WS); y++) begin
        for (int c = 0; c < 2; c++) begin
          logic [WS:0] e;
          @(posedge clk);
          sa = WS'(x); sb = WS'(y); sci = 1'(c);
          @(negedge clk);
          e = (WS+1)'(x + y + c);
          chk("R4 small sum", 64'(ss), 64'(e[WS-1:0]));
          chk("R5 small carry", 64'(sco), 64'(e[WS]));
        end
      end
    end

    // R6: carry_in reaches the bottom group
    run_big("R6", '0, '0, 1'b1);
    chk("R6 sum is one", 64'(s), 64'd1);
    // R7: carry through every group
    run_big("R7", '1, '0, 1'b1);
    chk("R7 sum zero", 64'(s), 64'd0);
    chk("R7 carry set", 64'(co), 64'd1);
    run_big("R7 ones", '1, '1, 1'b1);
    run_big("R4 alt", {(W/2){2'b10}}, {(W/2){2'b01}}, 1'b0);
    run_big("R7 alt", {(W/2){2'b10}}, {(W/2){2'b01}}, 1'b1);
    run_big("R4 alt2", {(W/2){2'b10}}, {(W/2){2'b10}}, 1'b1);

    // R8: group k handles bits 2k and 2k+1
    for (int k = 0; k < W/2; k++) begin
      logic [W:0] e;
      e = (W+1)'(1) << (2*k + 2);
      run_big("R8", W'(1) << (2*k + 1), W'(1) << (2*k + 1), 1'b0);
      chk("R8 group sum", 64'(s), 64'(e[W-1:0]));
      chk("R8 group carry", 64'(co), 64'(e[W]));
    end

    for (int n = 0; n < 1000; n++) begin
      run_big("R4 random", W'($urandom), W'($urandom), 1'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule